// File: doc/BRIEF.md
# Descriptor Chain Walker

This block walks one channel's linked list of 16-byte buffer descriptors. All descriptors sit in one contiguous area of host memory. The area's base address comes from a global register. A 16-bit slot index locates each descriptor, so its byte address is the base plus sixteen times the index.

The walker reads the four words of a descriptor over a simple word-read port. It then looks at the two-bit handshake field. When the field says the descriptor is ready, the walker passes the buffer's 64-bit physical address, its byte length and its end-of-frame flag to a datapath, using a valid/ready handoff. When the datapath pulses done, the walker writes the handshake field back and moves on to the next slot. The value written back is 0 if the descriptor's link flag marked the next index as valid, and 1 if it did not.

If the walker meets a descriptor that is not ready, it parks there until a resume strobe arrives. If it finishes a buffer whose link is invalid, it also parks, and on each resume it re-reads only the link word. A descriptor address that falls outside the area, or a misaligned area base, halts the channel with a sticky error flag. A buffer that is not 8-byte aligned in address and length does the same.

Descriptor layout, as 32-bit words at byte offsets 0, 4, 8 and 12 from the descriptor address:
- Word 0: low half of the buffer address.
- Word 1: high half of the buffer address.
- Word 2: length in bits [15:0], handshake field in bits [29:28], end-of-frame in bit 31.
- Word 3: next slot index in bits [15:0], link-valid flag in bit 31.

Handshake codes: 0 = finished with a valid link, 1 = finished with an invalid link, 2 = not ready, 3 = ready.

Top module: `desc_walker`

## Requirements
- R1: After `start`, the walker reads the descriptor words in the order 0, 1, 2, 3. Word k is read at `area_base + 16*index + 4*k`, where the index is first `start_idx`.
- R2: A descriptor whose word-2 bits [29:28] equal 3 is handed off with `buf_addr = {word1, word0}`, `buf_len = word2[15:0]` and `buf_eof = word2[31]`.
- R3: A descriptor whose handshake field is 0, 1 or 2 is not handed off and not written. The walker waits, and after each `resume` pulse it re-reads all four words of the same descriptor.
- R4: While `buf_valid` is high and `buf_ready` is low, `buf_valid`, `buf_addr`, `buf_len` and `buf_eof` hold their values.
- R5: After `buf_done`, the walker writes word 2 back to `descriptor address + 8` with bits [29:28] set to 0 if word3[31] is set and to 1 if it is clear. All other bits keep their fetched values. With a valid link, the next fetch starts at the slot given by word3[15:0].
- R6: After writing back code 1, the walker issues no access until `resume`. It then reads only word 3 (offset 12). If bit 31 is now set, it fetches the slot in bits [15:0]; otherwise it waits again.
- R7: If `area_base[3:0]` is nonzero, or the index addresses a slot at or beyond 2^AREA_LOG2 bytes into the area, `err` rises without any memory access. `err` stays high until reset, with no further reads or writes.
- R8: A ready descriptor whose buffer address bits [2:0] or length bits [2:0] are nonzero raises `err` instead of being handed off.
- R9: After reset, `rd_req`, `wr_req`, `buf_valid` and `err` are low.
- R10: `rd_req` and `wr_req` are never high together. Each request holds its address and stays high until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| area_base | input | 32 | Byte base address of the descriptor area |
| start | input | 1 | Start strobe, taken when idle |
| start_idx | input | IDX_W | Slot index of the first descriptor |
| resume | input | 1 | Retry strobe for a parked walker |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in the same cycle |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Word write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| buf_valid | output | 1 | Buffer handoff valid |
| buf_ready | input | 1 | Datapath accepts the buffer |
| buf_addr | output | 64 | Buffer physical address |
| buf_len | output | 16 | Buffer length in bytes |
| buf_eof | output | 1 | Buffer ends a frame |
| buf_done | input | 1 | Datapath finished the buffer |
| err | output | 1 | Sticky fault; the channel is halted |

## Verification
The bench lays out chains in a memory model and predicts every read address, handoff and write-back in order. The test patterns are:
- A three-slot chain with valid links. It separates index-based linking from sequential addressing and shows that the walker stops at a not-ready tail.
- A ready descriptor with a cleared link flag. It separates write-back code 1 from code 0 and shows that a resume then reads only the link word.
- A held-off `buf_ready`, which shows the handoff stays stable under backpressure.
- Faults, run separately after fresh resets: a misaligned buffer, an out-of-area index and a misaligned base. Each must raise the error with exactly the expected accesses, and the index and base faults with none at all.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int AREA_LOG2 = 20,
  parameter int IDX_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      area_base,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             resume,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_ack,
  input  logic [31:0]      rd_data,
  output logic             wr_req,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data,
  input  logic             wr_ack,
  output logic             buf_valid,
  input  logic             buf_ready,
  output logic [63:0]      buf_addr,
  output logic [15:0]      buf_len,
  output logic             buf_eof,
  input  logic             buf_done,
  output logic             err
);
  localparam int SLOT_W = AREA_LOG2 - 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_HAND, S_BUSY, S_WB, S_STALL, S_LWAIT, S_LRD, S_ERR
  } st_t;

  st_t              st;
  logic [31:0]      w0, w1, w2, w3;
  logic [1:0]       wi;
  logic [IDX_W-1:0] idx;
  logic [31:0]      desc_addr;
  logic             idx_oob, addr_bad, buf_bad, link_ok;

  assign desc_addr = area_base + 32'({idx, 4'b0000});
  assign idx_oob   = (SLOT_W < IDX_W) ? ((idx >> SLOT_W) != '0) : 1'b0;
  assign addr_bad  = (area_base[3:0] != 4'd0) || idx_oob;
  assign buf_bad   = (w0[2:0] != 3'd0) || (w2[2:0] != 3'd0);
  assign link_ok   = w3[31];

  assign rd_req  = (st == S_FETCH && !addr_bad) || st == S_LRD;
  assign rd_addr = desc_addr + ((st == S_LRD) ? 32'd12 : 32'({wi, 2'b00}));
  assign wr_req  = (st == S_WB);
  assign wr_addr = desc_addr + 32'd8;
  assign wr_data = {w2[31:30], 1'b0, !link_ok, w2[27:0]};

  assign buf_valid = (st == S_HAND);
  assign buf_addr  = {w1, w0};
  assign buf_len   = w2[15:0];
  assign buf_eof   = w2[31];
  assign err       = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      wi  <= '0;
      idx <= '0;
      w0  <= '0;
      w1  <= '0;
      w2  <= '0;
      w3  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            idx <= start_idx;
            wi  <= '0;
            st  <= S_FETCH;
          end
        S_FETCH:
          if (addr_bad) st <= S_ERR;
          else if (rd_ack) begin
            case (wi)
              2'd0: w0 <= rd_data;
              2'd1: w1 <= rd_data;
              2'd2: w2 <= rd_data;
              default: w3 <= rd_data;
            endcase
            if (wi == 2'd3) st <= S_CHECK;
            wi <= wi + 2'd1;
          end
        S_CHECK:
          if (w2[29:28] != 2'd3) st <= S_STALL;
          else if (buf_bad) st <= S_ERR;
          else st <= S_HAND;
        S_HAND:
          if (buf_ready) st <= S_BUSY;
        S_BUSY:
          if (buf_done) st <= S_WB;
        S_WB:
          if (wr_ack) begin
            if (link_ok) begin
              idx <= w3[IDX_W-1:0];
              wi  <= '0;
              st  <= S_FETCH;
            end else st <= S_LWAIT;
          end
        S_STALL:
          if (resume) begin
            wi <= '0;
            st <= S_FETCH;
          end
        S_LWAIT:
          if (resume) st <= S_LRD;
        S_LRD:
          if (rd_ack) begin
            w3 <= rd_data;
            if (rd_data[31]) begin
              idx <= rd_data[IDX_W-1:0];
              wi  <= '0;
              st  <= S_FETCH;
            end else st <= S_LWAIT;
          end
        default: st <= S_ERR;
      endcase
    end
  end

  // R4
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len) && $stable(buf_eof));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R5
  wb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_data[29] == 1'b0);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !rd_req && !wr_req && !buf_valid);

  // R1
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00 && ((rd_addr - area_base) >> AREA_LOG2) == 32'd0);
endmodule

// File: tb/desc_walker_bench.sv
`timescale 1ns/1ps
module desc_walker_bench;
  localparam int AREA_LOG2 = 12;
  localparam int IDX_W = 16;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] area_base = BASE;
  logic start = 0, resume = 0, buf_ready = 1;
  logic [IDX_W-1:0] start_idx = '0;
  logic rd_req, wr_req, rd_ack, wr_ack, buf_valid, buf_eof, buf_done, err;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [63:0] buf_addr;
  logic [15:0] buf_len;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_rd[$];
  logic [63:0] exp_wr[$];
  logic [95:0] exp_hd[$];
  logic [1:0]  dcnt;

  always #2.5 clk = ~clk;

  desc_walker #(.AREA_LOG2(AREA_LOG2), .IDX_W(IDX_W)) u_desc_walker (
    .clk(clk), .rst_n(rst_n), .area_base(area_base), .start(start), .start_idx(start_idx),
    .resume(resume), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_eof(buf_eof), .buf_done(buf_done), .err(err));

  function automatic int widx(input logic [31:0] a);
    logic [31:0] o;
    o = (a - BASE) >> 2;
    return int'(o[9:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 0; wr_ack <= 0; dcnt <= 0;
    end else begin
      rd_ack <= rd_req && !rd_ack;
      rd_data <= mem[widx(rd_addr)];
      wr_ack <= wr_req && !wr_ack;
      if (wr_req && !wr_ack) mem[widx(wr_addr)] <= wr_data;
      if (buf_valid && buf_ready) dcnt <= 2'd3;
      else if (dcnt != 0) dcnt <= dcnt - 2'd1;
    end
  end
  assign buf_done = (dcnt == 2'd1);

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (rd_req && rd_ack) begin
      if (exp_rd.size() == 0) chk(0, "R1/R3/R6 unexpected read", {64'd0, rd_addr}, 96'd0);
      else begin
        logic [31:0] e; e = exp_rd.pop_front();
        chk(rd_addr == e, "R1 read address", {64'd0, rd_addr}, {64'd0, e});
      end
    end
    if (wr_req && wr_ack) begin
      if (exp_wr.size() == 0) chk(0, "R3 unexpected write", {32'd0, wr_addr, wr_data}, 96'd0);
      else begin
        logic [63:0] e; e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R5 write-back", {32'd0, wr_addr, wr_data}, {32'd0, e});
      end
    end
    if (buf_valid && buf_ready) begin
      if (exp_hd.size() == 0) chk(0, "R2/R8 unexpected handoff", {15'd0, buf_addr, buf_len, buf_eof}, 96'd0);
      else begin
        logic [95:0] e; e = exp_hd.pop_front();
        chk({15'd0, buf_addr, buf_len, buf_eof} == e, "R2 handoff", {15'd0, buf_addr, buf_len, buf_eof}, e);
      end
    end
  end

  function automatic logic [31:0] dadr(input int idx);
    return BASE + 32'(idx * 16);
  endfunction

  // build a descriptor in memory
  task automatic put_desc(input int idx, input logic [63:0] ba, input logic [15:0] len,
                          input bit eof, input logic [1:0] sync, input bit lnk, input logic [15:0] nxt);
    int b; b = widx(dadr(idx));
    mem[b]   = ba[31:0];
    mem[b+1] = ba[63:32];
    mem[b+2] = {eof, 1'b0, sync, 12'd0, len};
    mem[b+3] = {lnk, 15'd0, nxt};
  endtask

  // driver: push expected reads of a full descriptor
  task automatic exp_fetch(input int idx);
    for (int k = 0; k < 4; k++) exp_rd.push_back(dadr(idx) + 32'(4 * k));
  endtask

  task automatic exp_buf(input int idx, input logic [63:0] ba, input logic [15:0] len,
                         input bit eof, input bit lnk);
    exp_hd.push_back({15'd0, ba, len, eof});
    exp_wr.push_back({dadr(idx) + 32'd8, eof, 1'b0, 1'b0, !lnk, 12'd0, len});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input int idx);
    @(negedge clk); start_idx = 16'(idx); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
  endtask

  task automatic drained(input string req);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0 && exp_hd.size() == 0, req,
        {32'(exp_rd.size()), 32'(exp_wr.size()), 32'(exp_hd.size())}, 96'd0);
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(3); rst_n = 1; cyc(1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    cyc(2);
    // R9 reset state
    chk({rd_req, wr_req, buf_valid, err} == 4'b0, "R9 reset outputs", {92'd0, rd_req, wr_req, buf_valid, err}, 96'd0);
    rst_n = 1; cyc(2);
    chk({rd_req, wr_req, buf_valid, err} == 4'b0, "R9 idle after reset", {92'd0, rd_req, wr_req, buf_valid, err}, 96'd0);

    // R1 R2 R5: chain 5 -> 9 -> 2 (2 not ready)
    put_desc(5, 64'h0000_0001_2000_0040, 16'd96, 0, 2'd3, 1, 16'd9);
    put_desc(9, 64'h0000_0002_3000_0008, 16'd48, 1, 2'd3, 1, 16'd2);
    put_desc(2, 64'h0, 16'd8, 0, 2'd2, 0, 16'd0);
    exp_fetch(5); exp_buf(5, 64'h0000_0001_2000_0040, 16'd96, 0, 1);
    exp_fetch(9); exp_buf(9, 64'h0000_0002_3000_0008, 16'd48, 1, 1);
    exp_fetch(2);
    pulse_start(5);
    cyc(80);
    drained("R1 R2 R5 chain walked");
    // R3 stalled on not-ready tail, nothing handed off or written
    chk(!buf_valid && !wr_req && !err, "R3 parked on not-ready", {93'd0, buf_valid, wr_req, err}, 96'd0);
    chk(mem[widx(dadr(2)) + 2][29:28] == 2'd2, "R3 tail untouched", {94'd0, mem[widx(dadr(2)) + 2][29:28]}, 96'd2);
    chk(mem[widx(dadr(9)) + 2][29:28] == 2'd0, "R5 code 0 stored", {94'd0, mem[widx(dadr(9)) + 2][29:28]}, 96'd0);

    // R3 R6: tail becomes ready with invalid link
    put_desc(2, 64'h0000_0000_4000_0100, 16'd64, 1, 2'd3, 0, 16'd0);
    exp_fetch(2); exp_buf(2, 64'h0000_0000_4000_0100, 16'd64, 1, 0);
    pulse_resume();
    cyc(40);
    drained("R3 R5 resume refetch, code 1");
    cyc(20); // R6 silence while parked (monitor flags any access)
    chk(!rd_req && !wr_req, "R6 no access before resume", {94'd0, rd_req, wr_req}, 96'd0);
    // link still invalid: only word 3 read, walker waits again
    exp_rd.push_back(dadr(2) + 32'd12);
    pulse_resume();
    cyc(15);
    drained("R6 link re-read, still invalid");
    // link now valid to slot 7 (not ready)
    mem[widx(dadr(2)) + 3] = {1'b1, 15'd0, 16'd7};
    put_desc(7, 64'h0, 16'd8, 0, 2'd2, 0, 16'd0);
    exp_rd.push_back(dadr(2) + 32'd12); exp_fetch(7);
    pulse_resume();
    cyc(30);
    drained("R6 link followed to slot 7");

    // R4 backpressure
    put_desc(7, 64'h0000_0003_0000_0200, 16'd16, 0, 2'd3, 0, 16'd0);
    buf_ready = 0;
    exp_fetch(7); exp_buf(7, 64'h0000_0003_0000_0200, 16'd16, 0, 0);
    pulse_resume();
    cyc(30);
    chk(buf_valid && buf_addr == 64'h0000_0003_0000_0200 && buf_len == 16'd16, "R4 held under backpressure",
        {15'd0, buf_addr, buf_len, buf_valid}, {15'd0, 64'h0000_0003_0000_0200, 16'd16, 1'b1});
    buf_ready = 1;
    cyc(30);
    drained("R4 accepted after backpressure");

    // R8 misaligned buffer
    exp_rd.delete(); exp_wr.delete(); exp_hd.delete();
    do_reset();
    put_desc(20, 64'h0000_0000_5000_0004, 16'd32, 0, 2'd3, 1, 16'd21);
    exp_fetch(20);
    pulse_start(20);
    cyc(30);
    chk(err, "R8 misaligned buffer error", {95'd0, err}, 96'd1);
    drained("R8 no handoff on misaligned buffer");

    // R7 index beyond area
    do_reset();
    pulse_start(300);
    cyc(10);
    chk(err, "R7 out-of-area index error", {95'd0, err}, 96'd1);
    drained("R7 no access on bad index");

    // R7 misaligned base
    do_reset();
    area_base = BASE + 32'd8;
    pulse_start(1);
    cyc(10);
    chk(err && !rd_req, "R7 misaligned base error", {94'd0, err, rd_req}, 96'd2);
    drained("R7 no access on bad base");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule